// File: doc/BRIEF.md
# Palette and Plane-Select Data Port

This block sits behind a host register write bus and serves one shared data port whose meaning is chosen by a mode bit in a control register. With the mode bit clear, a byte written to the data port picks which of four video memory planes receives host memory writes. The plane number comes out on a 2-bit output to the memory steering logic. With the mode bit set, the same port loads one of sixteen colour entries instead. The upper nibble of the byte names the entry and the lower nibble is the colour.

Colours are stored the way the host writes them: four IRGB bits, each active low. The display side presents a 4-bit pixel index every clock. The block looks the index up in the colour table and drives an active-high IRGB value one clock later. After reset the table maps every index to itself and plane 0 is selected, so a display works before software has programmed anything.

Top module: `pal_plane_port`

## Requirements
- R1: After reset, plane 0 is selected, the port is in plane-select mode, and colour entry n holds the inverse of n, so each pixel index n is shown as IRGB value n.
- R2: A host write to the control offset (9) loads bit 0 of the byte as the port mode (0 = plane select, 1 = colour load); bits 7..1 of that byte have no effect.
- R3: In colour-load mode, a write to the data offset (14) stores bits 3..0 of the byte into the entry selected by bits 7..4, and no other entry changes.
- R4: The IRGB output is registered: the value for the pixel index present at a rising edge appears just after that edge and holds until the next one.
- R5: Stored colours are active-low IRGB (bit 3 = I, bit 2 = R, bit 1 = G, bit 0 = B) and the output is their inverse: stored 0xF is shown as 0x0 (black), 0xE as 0x1 (blue), 0x0 as 0xF (white).
- R6: In plane-select mode, a write to the data offset loads bits 1..0 of the byte onto the plane output; bits 7..2 are ignored and the colour table is unchanged.
- R7: A data-offset write in colour-load mode leaves the plane output unchanged.
- R8: Writes to any other offset, and any cycle with the write enable low, change neither the plane output, the mode nor the colour table.
- R9: A mode change takes effect for the next data-offset write, and switching modes alters neither the stored plane nor the colour table.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 4 | Register offset within the port block |
| wr_data | input | 8 | Host write byte |
| pix_idx | input | 4 | Pixel colour index from the display stage |
| irgb_out | output | 4 | Active-high IRGB colour, one clock after the index |
| plane_sel | output | 2 | Memory plane that receives host memory writes |

## Verification
A wrong mode bit steers the next data-offset write to the wrong target. The plane output then keeps its old value or takes a value it should not, and this shows on the clock after that write. A misplaced or corrupted colour entry stays hidden until the display presents its index, then shows on irgb_out one clock later. For this reason the bench sweeps all sixteen indices after each kind of write. An inversion or bit-order error shows at once in the black, blue and white corner values.

// File: rtl/ppp_pkg.sv
package ppp_pkg;

   typedef enum logic {
      MODE_PLANE   = 1'b0,
      MODE_PALETTE = 1'b1
   } port_mode_e;

   // Reset colour for entry n: the active-low code whose inverse is n
   function automatic logic [7:0] reset_colour(input int unsigned n);
      logic [7:0] v;
      v = n[7:0];
      return ~v;
   endfunction

endpackage

// File: rtl/ppp_ctrl.sv
module ppp_ctrl #(
   parameter int ADDR_W   = 4,
   parameter int DATA_W   = 8,
   parameter int CTRL_OFS = 9,
   parameter int PORT_OFS = 14
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic [DATA_W-1:0]   wr_data,
   output ppp_pkg::port_mode_e mode,
   output logic                pal_we,
   output logic                plane_we
);
   import ppp_pkg::*;

   localparam logic [ADDR_W-1:0] CtrlAddr = ADDR_W'(CTRL_OFS);
   localparam logic [ADDR_W-1:0] PortAddr = ADDR_W'(PORT_OFS);

   logic ctrl_hit;
   logic port_hit;

   assign ctrl_hit = wr_en && (wr_addr == CtrlAddr);
   assign port_hit = wr_en && (wr_addr == PortAddr);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode <= MODE_PLANE;
      end else if (ctrl_hit) begin
         mode <= port_mode_e'(wr_data[0]);
      end
   end

   assign pal_we   = port_hit && (mode == MODE_PALETTE);
   assign plane_we = port_hit && (mode == MODE_PLANE);

endmodule

// File: rtl/ppp_palette.sv
module ppp_palette #(
   parameter int IDX_W   = 4,
   parameter int COLOR_W = 4,
   parameter bit OUT_REG = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [IDX_W-1:0]   w_idx,
   input  logic [COLOR_W-1:0] w_colour,
   input  logic [IDX_W-1:0]   r_idx,
   output logic [COLOR_W-1:0] r_irgb
);
   import ppp_pkg::*;

   localparam int NumEntries = 1 << IDX_W;

   logic [NumEntries-1:0][COLOR_W-1:0] entry_q;
   logic [COLOR_W-1:0]                 lookup_hi;

   for (genvar g = 0; g < NumEntries; g++) begin : g_entry
      localparam logic [7:0] RstFull = reset_colour(g);
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            entry_q[g] <= RstFull[COLOR_W-1:0];
         end else if (we && (w_idx == IDX_W'(g))) begin
            entry_q[g] <= w_colour;
         end
      end
   end

   // Stored codes are active low; the display side takes active high
   assign lookup_hi = ~entry_q[r_idx];

   if (OUT_REG) begin : g_out_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            r_irgb <= '0;
         end else begin
            r_irgb <= lookup_hi;
         end
      end
   end else begin : g_out_comb
      assign r_irgb = lookup_hi;
   end

endmodule

// File: rtl/ppp_plane.sv
module ppp_plane #(
   parameter int DATA_W  = 8,
   parameter int PLANE_W = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [DATA_W-1:0]  wr_data,
   output logic [PLANE_W-1:0] plane
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         plane <= '0;
      end else if (we) begin
         plane <= wr_data[PLANE_W-1:0];
      end
   end

endmodule

// File: rtl/pal_plane_port.sv
module pal_plane_port #(
   parameter int ADDR_W   = 4,
   parameter int DATA_W   = 8,
   parameter int IDX_W    = 4,
   parameter int COLOR_W  = 4,
   parameter int PLANES   = 4,
   parameter int CTRL_OFS = 9,
   parameter int PORT_OFS = 14,
   parameter bit OUT_REG  = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [ADDR_W-1:0]          wr_addr,
   input  logic [DATA_W-1:0]          wr_data,
   input  logic [IDX_W-1:0]           pix_idx,
   output logic [COLOR_W-1:0]         irgb_out,
   output logic [$clog2(PLANES)-1:0]  plane_sel
);
   import ppp_pkg::*;

   localparam int PlaneW = $clog2(PLANES);

   if (DATA_W < IDX_W + COLOR_W) begin : g_bad_split
      $error("data byte too narrow for index and colour fields");
   end
   if (PLANES < 2 || (1 << PlaneW) != PLANES) begin : g_bad_planes
      $error("plane count must be a power of two of at least 2");
   end
   if (PlaneW > DATA_W) begin : g_bad_plane_w
      $error("plane number wider than the data byte");
   end
   if (CTRL_OFS == PORT_OFS || CTRL_OFS >= (1 << ADDR_W) || PORT_OFS >= (1 << ADDR_W)) begin : g_bad_ofs
      $error("control and data offsets must be distinct and addressable");
   end

   port_mode_e pal_mode;
   logic       pal_we;
   logic       plane_we;

   ppp_ctrl #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .CTRL_OFS(CTRL_OFS),
      .PORT_OFS(PORT_OFS)
   ) ctrl_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .mode    (pal_mode),
      .pal_we  (pal_we),
      .plane_we(plane_we)
   );

   ppp_palette #(
      .IDX_W  (IDX_W),
      .COLOR_W(COLOR_W),
      .OUT_REG(OUT_REG)
   ) palette_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (pal_we),
      .w_idx   (wr_data[COLOR_W +: IDX_W]),
      .w_colour(wr_data[COLOR_W-1:0]),
      .r_idx   (pix_idx),
      .r_irgb  (irgb_out)
   );

   ppp_plane #(
      .DATA_W (DATA_W),
      .PLANE_W(PlaneW)
   ) plane_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (plane_we),
      .wr_data(wr_data),
      .plane  (plane_sel)
   );

endmodule

// File: rtl/pal_plane_port_chk.sv
module pal_plane_port_chk #(
   parameter int ADDR_W   = 4,
   parameter int DATA_W   = 8,
   parameter int IDX_W    = 4,
   parameter int COLOR_W  = 4,
   parameter int PLANE_W  = 2,
   parameter int CTRL_OFS = 9,
   parameter int PORT_OFS = 14,
   parameter bit OUT_REG  = 1'b1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               wr_en,
   input logic [ADDR_W-1:0]  wr_addr,
   input logic [DATA_W-1:0]  wr_data,
   input logic [IDX_W-1:0]   pix_idx,
   input logic [COLOR_W-1:0] irgb_out,
   input logic [PLANE_W-1:0] plane_sel,
   input logic               pal_mode
);

   logic ctrl_wr;
   logic port_wr;
   assign ctrl_wr = wr_en && (wr_addr == ADDR_W'(CTRL_OFS));
   assign port_wr = wr_en && (wr_addr == ADDR_W'(PORT_OFS));

   // R2
   mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr |=> (pal_mode == $past(wr_data[0])));

   // R8
   mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_wr |=> $stable(pal_mode));

   // R6
   plane_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (port_wr && !pal_mode) |=> (plane_sel == $past(wr_data[PLANE_W-1:0])));

   // R7
   plane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(port_wr && !pal_mode) |=> $stable(plane_sel));

   if (OUT_REG) begin : g_reg_chk
      // R3
      pal_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (port_wr && pal_mode) ##1 (pix_idx == $past(wr_data[COLOR_W +: IDX_W]))
         |=> (irgb_out == ~$past(wr_data[COLOR_W-1:0], 2)));
   end

endmodule

bind pal_plane_port pal_plane_port_chk #(
   .ADDR_W  (ADDR_W),
   .DATA_W  (DATA_W),
   .IDX_W   (IDX_W),
   .COLOR_W (COLOR_W),
   .PLANE_W ($clog2(PLANES)),
   .CTRL_OFS(CTRL_OFS),
   .PORT_OFS(PORT_OFS),
   .OUT_REG (OUT_REG)
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .wr_addr  (wr_addr),
   .wr_data  (wr_data),
   .pix_idx  (pix_idx),
   .irgb_out (irgb_out),
   .plane_sel(plane_sel),
   .pal_mode (pal_mode)
);

// File: tb/pal_plane_port_tb_top.sv
module pal_plane_port_tb_top;

   localparam int CLK_P = 10;
   localparam logic [3:0] CTRL_A = 4'd9;
   localparam logic [3:0] PORT_A = 4'd14;

   typedef struct {
      logic [3:0] idx;
      logic [3:0] exp;
      string      tag;
   } look_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [3:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [3:0] pix_idx = '0;
   logic [3:0] irgb_out;
   logic [1:0] plane_sel;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [3:0] m_pal [16];
   logic       m_mode;
   logic [1:0] m_plane;
   logic [3:0] last_exp;
   look_t      exp_q [$];

   pal_plane_port dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .pix_idx  (pix_idx),
      .irgb_out (irgb_out),
      .plane_sel(plane_sel)
   );

   always #(CLK_P/2) clk = ~clk;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   // Driver: host write, model updated from the requirements
   task automatic host_wr(input logic [3:0] a, input logic [7:0] d, input logic en = 1'b1);
      @(negedge clk);
      wr_en = en; wr_addr = a; wr_data = d;
      if (en && a == CTRL_A) m_mode = d[0];
      else if (en && a == PORT_A) begin
         if (m_mode) m_pal[d[7:4]] = d[3:0];
         else        m_plane = d[1:0];
      end
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // Driver: present an index, push its expected colour
   task automatic lookup(input logic [3:0] i, input string tag);
      look_t it;
      @(negedge clk);
      pix_idx = i;
      it.idx = i; it.exp = ~m_pal[i]; it.tag = tag;
      exp_q.push_back(it);
      last_exp = it.exp;
   endtask

   task automatic sweep(input string tag);
      for (int i = 0; i < 16; i++) lookup(4'(i), tag);
   endtask

   // Monitor: compare just after each rising edge
   initial begin
      look_t it;
      forever begin
         @(posedge clk);
         #2;
         if (exp_q.size() > 0) begin
            it = exp_q.pop_front();
            check(irgb_out == it.exp, it.tag, irgb_out, it.exp);
         end
      end
   end

   initial begin
      #(CLK_P * 20000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      m_mode = 1'b0; m_plane = 2'd0;
      for (int i = 0; i < 16; i++) m_pal[i] = ~4'(i);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      @(negedge clk);
      check(plane_sel == 2'd0, "R1 plane after reset", plane_sel, 0);
      sweep("R1 identity map");

      // R6: plane mode, upper bits ignored, table untouched
      host_wr(PORT_A, 8'hF6);
      check(plane_sel == 2'd2, "R6 plane load 0xF6", plane_sel, 2);
      sweep("R6 table unchanged");

      // R2: control bits 7..1 ignored, mode stays plane select
      host_wr(CTRL_A, 8'hFE);
      host_wr(PORT_A, 8'h03);
      check(plane_sel == 2'd3, "R2 mode bit 0 only", plane_sel, 3);

      // R5 / R3: colour-load mode with the corner colours
      host_wr(CTRL_A, 8'h01);
      host_wr(PORT_A, 8'h5F);
      host_wr(PORT_A, 8'h30);
      host_wr(PORT_A, 8'h7E);
      check(plane_sel == 2'd3, "R7 plane held in colour mode", plane_sel, 3);
      lookup(4'd5, "R5 black");
      lookup(4'd3, "R5 white");
      lookup(4'd7, "R5 blue");
      sweep("R3 only named entries change");

      // R8: other offset and strobe low
      host_wr(4'd0, 8'h2A);
      host_wr(PORT_A, 8'h2A, 1'b0);
      host_wr(CTRL_A, 8'h00, 1'b0);
      check(plane_sel == 2'd3, "R8 plane untouched", plane_sel, 3);
      lookup(4'd2, "R8 entry untouched");
      host_wr(PORT_A, 8'h9C);
      lookup(4'd9, "R8 mode still colour load");

      // R3: full table rewrite
      for (int i = 0; i < 16; i++) host_wr(PORT_A, {4'(i), 4'(i * 7 + 3)});
      sweep("R3 full rewrite");

      // R4: output holds until the next rising edge
      lookup(4'd1, "R4 settle");
      begin
         logic [3:0] prev;
         prev = last_exp;
         @(posedge clk); #3;
         @(negedge clk);
         pix_idx = 4'd12;
         #1;
         check(irgb_out == prev, "R4 holds before edge", irgb_out, prev);
         @(posedge clk); #2;
         check(irgb_out == ~m_pal[12], "R4 updates after edge", irgb_out, ~m_pal[12]);
      end

      // R9: back to plane select, table and plane kept over the switch
      host_wr(CTRL_A, 8'h00);
      check(plane_sel == 2'd3, "R9 plane kept over switch", plane_sel, 3);
      host_wr(PORT_A, 8'h41);
      check(plane_sel == 2'd1, "R9 next write is plane", plane_sel, 1);
      sweep("R9 table kept");

      repeat (3) @(negedge clk);
      done = 1'b1;
      summary();
      $finish;
   end

endmodule